// File: doc/BRIEF.md
# Saturating Q31 Multiply-Subtract Accumulator

This block multiplies two signed Q31 fractions and subtracts the result from one of four 64-bit Q63 accumulators, saturating at both stages. Each operation is one strobe carrying two 32-bit operands and a 2-bit accumulator index. The product is the signed 64-bit product shifted left by one. The single case that cannot be represented, -1.0 times -1.0, is clamped to the largest positive Q63 value. The subtraction is computed at 65 bits. If bits 64 and 63 of the difference disagree, the result is clamped: to the most negative Q63 value when bit 64 is set, and to the most positive value otherwise.

Saturation at either stage raises no exception. It sets a sticky flag in a 32-bit status word, at bit 16 plus the accumulator index. Software-facing logic reads the accumulators through a combinational read port. It can also clear the flags or overwrite the status word.

Top module: `q31_msub_acc`

## Requirements
- R1: On a strobe whose product and difference are both in range, the selected accumulator becomes its old value minus 2*a*b on the next clock edge, with a and b read as signed 32-bit integers.
- R2: When both operands are 0x80000000, the product used is 0x7FFFFFFFFFFFFFFF, and status bit 16+index is set.
- R3: When the 65-bit difference has bit 64 set and bit 63 clear, the accumulator becomes 0x8000000000000000.
- R4: When the 65-bit difference has bit 64 clear and bit 63 set, the accumulator becomes 0x7FFFFFFFFFFFFFFF.
- R5: Any saturation during an operation on accumulator k sets status bit 16+k and leaves the flag bits of the other accumulators unchanged.
- R6: Flag bits 16..19 are sticky: nothing clears them except flag_clr or a status write.
- R7: flag_clr clears only bits 16..19. If a saturating operation happens in the same cycle, its flag is still set.
- R8: status_we loads the whole status word from status_wdata. Without it, bits outside 16..19 never change. In a cycle with both status_we and flag_clr, the write is applied first and the clear second.
- R9: Only the indexed accumulator is written, and only when op_valid is high.
- R10: After reset, all accumulators and the status word are zero.
- R11: rd_hi and rd_lo show the upper and lower halves of the accumulator selected by rd_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Operation strobe |
| op_a | input | 32 | First Q31 operand |
| op_b | input | 32 | Second Q31 operand |
| op_idx | input | 2 | Accumulator index for the operation |
| flag_clr | input | 1 | Clear flag bits 16..19 |
| status_we | input | 1 | Load status word |
| status_wdata | input | 32 | Value for status load |
| rd_idx | input | 2 | Accumulator read-back select |
| rd_hi | output | 32 | Upper half of the selected accumulator |
| rd_lo | output | 32 | Lower half of the selected accumulator |
| status_o | output | 32 | Status word |

## Verification
A wrong accumulator value shows up on the read port in the cycle after the strobe. From then on it persists, because every later subtraction starts from it. A flag set at the wrong position, or cleared when it should not be, shows on status_o one edge after the operation and stays there. The bench therefore reads all four accumulators and the status word after every clock. It compares them with a 128-bit arithmetic model, so any divergence is caught at the edge where it first appears.

// File: rtl/msub_pkg.sv
package msub_pkg;
  parameter int DATA_W   = 32;
  parameter int NUM_ACC  = 4;
  parameter int STAT_W   = 32;
  parameter int FLAG_LSB = 16;
endpackage

// File: rtl/q31_product.sv
module q31_product #(
  parameter int DW = msub_pkg::DATA_W,
  localparam int PW = 2 * DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [PW-1:0] prod,
  output logic          prod_sat
);
  localparam logic [DW-1:0] MIN_IN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [PW-1:0] MAX_OUT = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] full;

  always_comb begin
    full     = $signed(a) * $signed(b);
    prod_sat = (a == MIN_IN) && (b == MIN_IN);
    prod     = prod_sat ? MAX_OUT : {full[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/q63_sub_sat.sv
module q63_sub_sat #(
  parameter int W = 2 * msub_pkg::DATA_W
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] diff;

  always_comb begin
    diff = {acc[W-1], acc} - {sub[W-1], sub};
    ovf  = diff[W] ^ diff[W-1];
    if (!ovf)         res = diff[W-1:0];
    else if (diff[W]) res = NEG_MIN;
    else              res = POS_MAX;
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int NACC     = msub_pkg::NUM_ACC,
  parameter int AW       = 2 * msub_pkg::DATA_W,
  parameter int SW       = msub_pkg::STAT_W,
  parameter int FLAG_LSB = msub_pkg::FLAG_LSB,
  localparam int IW = $clog2(NACC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          set_flag,
  input  logic          flag_clr,
  input  logic          st_we,
  input  logic [SW-1:0] st_wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] cur_data,
  output logic [SW-1:0] status
);
  localparam logic [SW-1:0] FMASK = SW'(((1 << NACC) - 1) << FLAG_LSB);

  logic [AW-1:0] acc_q [NACC];
  logic [AW-1:0] acc_d [NACC];
  logic [SW-1:0] st_q, st_d;
  logic          upd_en;

  always_comb begin
    acc_d = acc_q;
    if (wr_en) acc_d[wr_idx] = wr_data;
    st_d = st_q;
    if (st_we)    st_d = st_wdata;
    if (flag_clr) st_d = st_d & ~FMASK;
    if (wr_en && set_flag) st_d[FLAG_LSB + int'(wr_idx)] = 1'b1;
    upd_en = wr_en | st_we | flag_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NACC; k++) acc_q[k] <= '0;
      st_q <= '0;
    end else if (upd_en) begin
      acc_q <= acc_d;
      st_q  <= st_d;
    end
  end

  assign rd_data  = acc_q[rd_idx];
  assign cur_data = acc_q[wr_idx];
  assign status   = st_q;

  for (genvar k = 0; k < NACC; k++) begin : g_chk
    p_hold_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_idx != IW'(k)) |=> $stable(acc_q[k]));
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && set_flag && wr_idx == IW'(k)) |=> st_q[FLAG_LSB + k]);
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && !st_we) |=> ((~st_q & $past(st_q) & FMASK) == '0));
  p_other_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> ((st_q & ~FMASK) == ($past(st_q) & ~FMASK)));
endmodule

// File: rtl/q31_msub_acc.sv
module q31_msub_acc #(
  parameter int DW       = msub_pkg::DATA_W,
  parameter int NACC     = msub_pkg::NUM_ACC,
  parameter int SW       = msub_pkg::STAT_W,
  parameter int FLAG_LSB = msub_pkg::FLAG_LSB,
  localparam int PW = 2 * DW,
  localparam int IW = $clog2(NACC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [IW-1:0] op_idx,
  input  logic          flag_clr,
  input  logic          status_we,
  input  logic [SW-1:0] status_wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo,
  output logic [SW-1:0] status_o
);
  localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] NEG_MIN = {1'b1, {(PW-1){1'b0}}};
  localparam logic [DW-1:0] MIN_IN  = {1'b1, {(DW-1){1'b0}}};

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [PW-1:0] prod, cur, res, rd_data;
  logic          prod_sat, ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  q31_product #(.DW(DW)) u_prod (
    .a(op_a), .b(op_b), .prod(prod), .prod_sat(prod_sat));

  q63_sub_sat #(.W(PW)) u_sub (
    .acc(cur), .sub(prod), .res(res), .ovf(ovf));

  acc_bank #(.NACC(NACC), .AW(PW), .SW(SW), .FLAG_LSB(FLAG_LSB)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(op_valid), .wr_idx(op_idx), .wr_data(res),
    .set_flag(prod_sat | ovf),
    .flag_clr(flag_clr), .st_we(status_we), .st_wdata(status_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data), .cur_data(cur), .status(status_o));

  assign rd_hi = rd_data[PW-1:DW];
  assign rd_lo = rd_data[DW-1:0];

  p_minmin_clamp_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_a == MIN_IN && op_b == MIN_IN) |-> (prod_sat && prod == POS_MAX));
  p_sat_extreme_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && ovf) |-> (res == NEG_MIN || res == POS_MAX));
  p_no_sat_sign_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !ovf) |-> (res == cur - prod));
endmodule

// File: tb/tb_q31_msub_acc.sv
module tb_q31_msub_acc;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMIN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  op_idx = '0, rd_idx = '0;
  logic        flag_clr = 1'b0, status_we = 1'b0;
  logic [31:0] status_wdata = '0;
  logic [31:0] rd_hi, rd_lo, status_o;

  int tests = 0, fails = 0;
  logic [63:0] m_acc [4];
  logic [31:0] m_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  q31_msub_acc dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      rd_idx = 2'(k);
      #1;
      chk({req, " acc (R11)"}, {rd_hi, rd_lo}, m_acc[k]);
    end
    chk({req, " status"}, {32'h0, status_o}, {32'h0, m_st});
  endtask

  task automatic model_step(input logic v, input logic [31:0] a, input logic [31:0] b,
                            input logic [1:0] idx, input logic clr, input logic we,
                            input logic [31:0] wd);
    logic signed [127:0] p, d;
    logic sat;
    p = $signed({{96{a[31]}}, a}) * $signed({{96{b[31]}}, b}) * 2;
    sat = 1'b0;
    if (p > $signed({64'h0, PMAX})) begin p = $signed({64'h0, PMAX}); sat = 1'b1; end
    d = $signed({{64{m_acc[idx][63]}}, m_acc[idx]}) - p;
    if (d > $signed({64'h0, PMAX})) begin d = {64'h0, PMAX}; sat = 1'b1; end
    else if (d < $signed({{64{1'b1}}, NMIN})) begin d = {{64{1'b1}}, NMIN}; sat = 1'b1; end
    if (we) m_st = wd;
    if (clr) m_st[19:16] = 4'h0;
    if (v) begin
      m_acc[idx] = d[63:0];
      if (sat) m_st[16 + int'(idx)] = 1'b1;
    end
  endtask

  task automatic step(input string req, input logic v, input logic [31:0] a,
                      input logic [31:0] b, input logic [1:0] idx,
                      input logic clr = 1'b0, input logic we = 1'b0,
                      input logic [31:0] wd = 32'h0);
    op_valid = v; op_a = a; op_b = b; op_idx = idx;
    flag_clr = clr; status_we = we; status_wdata = wd;
    model_step(v, a, b, idx, clr, we, wd);
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_acc[k] = '0;
    m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R10 reset");
    // R1 plain operations on several accumulators
    step("R1 basic", 1, 32'h4000_0000, 32'h2000_0000, 2'd0);
    step("R1 neg", 1, 32'hC000_0000, 32'h1234_5678, 2'd3);
    step("R1 small", 1, 32'h0000_0003, 32'hFFFF_FFFB, 2'd2);
    // R9 strobe low changes nothing
    step("R9 idle", 0, 32'h8000_0000, 32'h8000_0000, 2'd0);
    // R2 minus one times minus one, on acc1
    step("R2 minmin", 1, 32'h8000_0000, 32'h8000_0000, 2'd1);
    // R4 positive overflow on acc2: subtract large negative products
    step("R4 pos a", 1, 32'h8000_0000, 32'h7FFF_FFFF, 2'd2);
    step("R4 pos b", 1, 32'h8000_0000, 32'h7FFF_FFFF, 2'd2);
    // R6 sticky: an in-range op on acc2 keeps the flag
    step("R6 sticky", 1, 32'h0000_0010, 32'h0000_0010, 2'd2);
    // R3 negative overflow on acc3
    step("R3 neg a", 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd3);
    step("R3 neg b", 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd3);
    // R5 flag isolation: acc0 unaffected so far
    chk("R5 isolation bit16", {63'h0, status_o[16]}, 64'h0);
    // R8 status write of whole word
    step("R8 write", 0, 0, 0, 2'd0, 1'b0, 1'b1, 32'hA5A0_0F3C);
    // R7 clear with a same-cycle saturating op on acc0
    step("R7 clr+sat", 1, 32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1);
    step("R7 clr", 0, 0, 0, 2'd0, 1'b1);
    // R8 write then clear in one cycle
    step("R8 we+clr", 0, 0, 0, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    for (int i = 0; i < 300; i++)
      step("R1 random", 1'($urandom), $urandom, $urandom, 2'($urandom),
           ($urandom % 16) == 0, ($urandom % 32) == 0, $urandom);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule